// File: doc/BRIEF.md
# Multiplexed-Address DRAM to Flat SRAM Adapter

This block sits between a memory controller designed for multiplexed-address DRAM and a byte-wide static RAM with a flat address. The controller puts the row half of the address on a shared bus and drops the row strobe, then puts the column half on the same bus and drops the column strobe. The adapter samples both active-low strobes on a fast system clock, captures each half of the address on the strobe's falling edge, and joins them into one flat SRAM address. The most significant SRAM address bit selects one of two equal banks.

Writes arrive one byte at a time through two active-low bank write enables. The adapter writes only the bank or banks whose enable is low; if both are low it writes bank 0 and then bank 1 in back-to-back cycles. A cycle with both enables high is a word read: the adapter reads bank 0 and bank 1 at the captured address, presents the bank 0 byte while the column strobe is low, and switches its output to the stored bank 1 byte when the column strobe rises.

All SRAM controls come from registers. The chip enable is active only while the column strobe is low or an access is still running, and the output enable is active only during the read sequence.

Top module: `dram_sram_bridge`

## Requirements
- R1: On a synchronized falling edge of `ras_n`, `mux_addr` is captured and drives `sram_addr[2*AW-1:AW]` in every following access.
- R2: On a synchronized falling edge of `cas_n`, `mux_addr` is captured and drives `sram_addr[AW-1:0]`.
- R3: Each strobe passes through SYNC_STAGES flops before edge detection; with the default of two stages, an access starts on the fourth rising clock edge after `cas_n` falls, so `busy` is still 0 after the third and 1 after the fourth.
- R4: `sram_addr[2*AW]` is the bank bit: 0 selects bank 0, 1 selects bank 1.
- R5: When exactly one of `we0_n`/`we1_n` is low as the access starts, `wr_data` is written to that bank only, with `sram_we_n` low for one cycle and `busy` back to 0 one edge later.
- R6: When both write enables are low, bank 0 is written and then bank 1 in the next cycle with the same byte; `busy` stays 1 over both write cycles.
- R7: When both write enables are high, the block reads bank 0 for one cycle and then bank 1 for one cycle with `sram_oe_n` low, at the captured address.
- R8: Two edges after the read starts, `rd_data` shows the bank 0 byte and holds it while `cas_n` stays low.
- R9: After a synchronized rising edge of `cas_n`, `rd_data` shows the bank 1 byte of the last read.
- R10: `sram_ce_n` is low only while the synchronized `cas_n` is low or an access is running; `sram_oe_n` and `sram_we_n` are never low together.
- R11: After reset `sram_ce_n`, `sram_oe_n`, `sram_we_n` are 1, `busy` is 0, and `rd_data` and `sram_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we0_n | input | 1 | Active-low write enable for bank 0 |
| we1_n | input | 1 | Active-low write enable for bank 1 |
| mux_addr | input | AW | Shared row/column address bus |
| wr_data | input | DW | Byte to write |
| rd_data | output | DW | Byte returned to the controller |
| busy | output | 1 | An SRAM access sequence is running |
| sram_addr | output | 2*AW+1 | Flat SRAM address, bank bit on top |
| sram_wdata | output | DW | Byte driven to the SRAM |
| sram_rdata | input | DW | Byte read from the SRAM |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write enable |

## Verification
Counting from the clock edges after the bench lowers `cas_n`, the chip enable is due after the second edge, `busy` and the first SRAM control after the fourth, the bank 1 address or second write after the fifth, and the bank 0 read byte after the sixth; the bank 1 byte is due after the third edge following the rise of `cas_n`. The bench waits exactly that many rising edges and then samples at the next falling edge, checking both the cycle before a result and the cycle it appears where the timing matters. A behavioural SRAM in the bench takes the writes, and a sweep over every address of a 4-bit multiplexed bus writes each bank separately and then reads every word back against values computed from the address.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_WR_HI  = 3'd1,
    SEQ_WR_END = 3'd2,
    SEQ_RD_LO  = 3'd3,
    SEQ_RD_HI  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/dsb_strobe_sync.sv
module dsb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic level_n,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_n;

  // Strobes idle high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '1;
      last_n <= 1'b1;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        chain[i] <= chain[i-1];
      end
      chain[0] <= strobe_n;
      last_n   <= chain[STAGES-1];
    end
  end

  assign level_n = chain[STAGES-1];
  assign fall    = last_n & ~level_n;
  assign rise    = ~last_n & level_n;

endmodule

// File: rtl/dsb_addr_capture.sv
module dsb_addr_capture #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_fall,
  input  logic          col_fall,
  input  logic [AW-1:0] mux_addr,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic          go
);

  // The column half is complete on the column edge; the access starts one clock later.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
      go    <= 1'b0;
    end else begin
      if (row_fall) row_q <= mux_addr;
      if (col_fall) col_q <= mux_addr;
      go <= col_fall;
    end
  end

endmodule

// File: rtl/dsb_access_seq.sv
module dsb_access_seq
  import dsb_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int SAW = 2 * AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           we0_n,
  input  logic           we1_n,
  input  logic [AW-1:0]  row_q,
  input  logic [AW-1:0]  col_q,
  input  logic [DW-1:0]  wr_data,
  output seq_state_t     state,
  output logic [SAW-1:0] sram_addr,
  output logic [DW-1:0]  sram_wdata,
  output logic           sram_we_n,
  output logic           sram_oe_n
);

  logic any_wr;
  logic dual_wr;

  assign any_wr  = ~we0_n | ~we1_n;
  assign dual_wr = ~we0_n & ~we1_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (go) begin
            if (any_wr) begin
              // Bank bit follows the enable that is low; with both low, bank 0 goes first.
              sram_addr  <= {we0_n, row_q, col_q};
              sram_wdata <= wr_data;
              sram_we_n  <= 1'b0;
              state      <= dual_wr ? SEQ_WR_HI : SEQ_WR_END;
            end else begin
              sram_addr <= {1'b0, row_q, col_q};
              sram_oe_n <= 1'b0;
              state     <= SEQ_RD_LO;
            end
          end
        end
        SEQ_WR_HI: begin
          sram_addr[SAW-1] <= 1'b1;
          state            <= SEQ_WR_END;
        end
        SEQ_WR_END: begin
          sram_we_n <= 1'b1;
          state     <= SEQ_IDLE;
        end
        SEQ_RD_LO: begin
          sram_addr[SAW-1] <= 1'b1;
          state            <= SEQ_RD_HI;
        end
        SEQ_RD_HI: begin
          sram_oe_n <= 1'b1;
          state     <= SEQ_IDLE;
        end
        default: begin
          sram_we_n <= 1'b1;
          sram_oe_n <= 1'b1;
          state     <= SEQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dsb_read_hold.sv
module dsb_read_hold
  import dsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state,
  input  logic          col_rise,
  input  logic [DW-1:0] sram_rdata,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] lo_byte;
  logic [DW-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_byte <= '0;
      hi_byte <= '0;
      rd_data <= '0;
    end else begin
      if (state == SEQ_RD_LO) lo_byte <= sram_rdata;
      if (state == SEQ_RD_HI) begin
        hi_byte <= sram_rdata;
        rd_data <= lo_byte;
      end else if (col_rise) begin
        rd_data <= hi_byte;
      end
    end
  end

endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge
  import dsb_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SAW        = 2 * AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we0_n,
  input  logic           we1_n,
  input  logic [AW-1:0]  mux_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic [SAW-1:0] sram_addr,
  output logic [DW-1:0]  sram_wdata,
  input  logic [DW-1:0]  sram_rdata,
  output logic           sram_ce_n,
  output logic           sram_oe_n,
  output logic           sram_we_n
);

  logic          ras_level_unused;
  logic          ras_rise_unused;
  logic          ras_fall;
  logic          cas_level_n;
  logic          cas_fall;
  logic          cas_rise;
  logic [AW-1:0] row_q;
  logic [AW-1:0] col_q;
  logic          go;
  seq_state_t    state;

  dsb_strobe_sync #(.STAGES(SYNC_STAGES)) u_ras_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (ras_n),
    .level_n  (ras_level_unused),
    .fall     (ras_fall),
    .rise     (ras_rise_unused)
  );

  dsb_strobe_sync #(.STAGES(SYNC_STAGES)) u_cas_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (cas_n),
    .level_n  (cas_level_n),
    .fall     (cas_fall),
    .rise     (cas_rise)
  );

  dsb_addr_capture #(.AW(AW)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .row_fall (ras_fall),
    .col_fall (cas_fall),
    .mux_addr (mux_addr),
    .row_q    (row_q),
    .col_q    (col_q),
    .go       (go)
  );

  dsb_access_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .we0_n      (we0_n),
    .we1_n      (we1_n),
    .row_q      (row_q),
    .col_q      (col_q),
    .wr_data    (wr_data),
    .state      (state),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n)
  );

  dsb_read_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .col_rise   (cas_rise),
    .sram_rdata (sram_rdata),
    .rd_data    (rd_data)
  );

  assign busy      = (state != SEQ_IDLE);
  assign sram_ce_n = cas_level_n & ~busy;

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int SAW = 19
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           sram_ce_n,
  input logic           sram_oe_n,
  input logic           sram_we_n,
  input logic [SAW-1:0] sram_addr
);

  // R10: write and output enables never overlap
  p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n);

  // R10: any SRAM strobe implies chip enable
  p_ce_cover_r10: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n || !sram_oe_n) |-> !sram_ce_n);

  // R7: first read cycle addresses bank 0
  p_rd_first_r7: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n && $past(sram_oe_n)) |-> !sram_addr[SAW-1]);

  // R7: second read cycle addresses bank 1
  p_rd_second_r7: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n && !$past(sram_oe_n)) |-> sram_addr[SAW-1]);

  // R6: back-to-back writes go bank 0 then bank 1
  p_dual_order_r6: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |-> (sram_addr[SAW-1] && !$past(sram_addr[SAW-1])));

  // R6: a write cycle is always inside a busy window
  p_wr_busy_r6: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> busy);

  // R5: at most two write cycles in a row
  p_wr_len_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |=> sram_we_n);

endmodule

bind dram_sram_bridge dsb_checker #(.SAW(SAW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_addr (sram_addr)
);

// File: tb/dram_sram_bridge_test.sv
module dram_sram_bridge_test;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int SAW = 2 * AW + 1;
  localparam int NW  = 1 << (2 * AW);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ras_n = 1'b1;
  logic           cas_n = 1'b1;
  logic           we0_n = 1'b1;
  logic           we1_n = 1'b1;
  logic [AW-1:0]  mux_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [DW-1:0]  rd_data;
  logic           busy;
  logic [SAW-1:0] sram_addr;
  logic [DW-1:0]  sram_wdata;
  logic [DW-1:0]  sram_rdata;
  logic           sram_ce_n;
  logic           sram_oe_n;
  logic           sram_we_n;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  logic [DW-1:0] mem [0:(1<<SAW)-1];

  always #5 clk = ~clk;

  dram_sram_bridge #(.AW(AW), .DW(DW)) uut (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we0_n      (we0_n),
    .we1_n      (we1_n),
    .mux_addr   (mux_addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .busy       (busy),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_rdata (sram_rdata),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
  );

  // Behavioural SRAM
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_wdata;
  end
  assign sram_rdata = sram_oe_n ? '0 : mem[sram_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int v0(input int r, input int c);
    return ((r * 16 + c) * 7 + 3) & 255;
  endfunction

  function automatic int v1(input int r, input int c);
    return (((r * 16 + c) * 13) ^ 8'hA5) & 255;
  endfunction

  function automatic int flat(input int bank, input int r, input int c);
    return (bank << (2 * AW)) | (r << AW) | c;
  endfunction

  // One full strobe cycle; w0n/w1n both high means a read.
  task automatic access(input int r, input int c, input bit w0n, input bit w1n,
                        input int data, input int exp_lo, input int exp_hi);
    bit is_rd;
    bit dual;
    is_rd = w0n && w1n;
    dual  = !w0n && !w1n;
    @(negedge clk);
    mux_addr = AW'(r);
    ras_n    = 1'b0;
    repeat (4) @(negedge clk);
    mux_addr = AW'(c);
    we0_n    = w0n;
    we1_n    = w1n;
    wr_data  = DW'(data);
    cas_n    = 1'b0;
    // after third edge: strobe seen, access not yet started
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R3 busy before start", busy, 0);
    check(sram_ce_n == 1'b0, "R10 ce with cas low", sram_ce_n, 0);
    // after fourth edge
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R3 busy at start", busy, 1);
    if (is_rd) begin
      check(sram_oe_n == 1'b0, "R7 oe first read", sram_oe_n, 0);
      check(int'(sram_addr) == flat(0, r, c), "R1 R2 R4 bank0 read address",
            int'(sram_addr), flat(0, r, c));
    end else begin
      check(sram_we_n == 1'b0, "R5 write pulse", sram_we_n, 0);
      check(int'(sram_addr) == flat(w0n ? 1 : 0, r, c), "R4 R5 write address",
            int'(sram_addr), flat(w0n ? 1 : 0, r, c));
      check(int'(sram_wdata) == data, "R5 write data", int'(sram_wdata), data);
    end
    // after fifth edge
    @(posedge clk); @(negedge clk);
    if (is_rd) begin
      check(sram_oe_n == 1'b0 && int'(sram_addr) == flat(1, r, c), "R7 bank1 read",
            int'(sram_addr), flat(1, r, c));
    end else if (dual) begin
      check(busy && !sram_we_n && int'(sram_addr) == flat(1, r, c), "R6 second write",
            int'(sram_addr), flat(1, r, c));
    end else begin
      check(busy == 1'b0 && sram_we_n == 1'b1, "R5 single write ends", busy, 0);
    end
    // after sixth edge
    @(posedge clk); @(negedge clk);
    check(busy == 1'b0 && sram_oe_n && sram_we_n, "R6 R7 sequence ends", busy, 0);
    if (is_rd) check(int'(rd_data) == exp_lo, "R8 bank0 byte", int'(rd_data), exp_lo);
    repeat (2) @(negedge clk);
    if (is_rd) check(int'(rd_data) == exp_lo, "R8 bank0 byte held", int'(rd_data), exp_lo);
    cas_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (is_rd) check(int'(rd_data) == exp_hi, "R9 bank1 byte", int'(rd_data), exp_hi);
    check(sram_ce_n == 1'b1, "R10 ce released", sram_ce_n, 1);
    ras_n = 1'b1;
    we0_n = 1'b1;
    we1_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << SAW); i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(sram_ce_n && sram_oe_n && sram_we_n, "R11 strobes idle", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    check(busy == 1'b0, "R11 busy", busy, 0);
    check(rd_data == '0, "R11 rd_data", int'(rd_data), 0);
    check(sram_addr == '0, "R11 sram_addr", int'(sram_addr), 0);

    // Bank 0 only writes, then bank 1 only writes
    for (int a = 0; a < NW; a++) access(a >> AW, a % (1 << AW), 1'b0, 1'b1, v0(a >> AW, a % (1 << AW)), 0, 0);
    for (int a = 0; a < NW; a++) access(a >> AW, a % (1 << AW), 1'b1, 1'b0, v1(a >> AW, a % (1 << AW)), 0, 0);
    // Read every word: bank 0 untouched by bank 1 writes and vice versa (R5)
    for (int a = 0; a < NW; a++)
      access(a >> AW, a % (1 << AW), 1'b1, 1'b1, 0, v0(a >> AW, a % (1 << AW)), v1(a >> AW, a % (1 << AW)));

    // Both enables low: same byte into both banks (R6)
    for (int r = 0; r < (1 << AW); r++) access(r, (1 << AW) - 1 - r, 1'b0, 1'b0, 8'h3C ^ r, 0, 0);
    for (int r = 0; r < (1 << AW); r++) access(r, (1 << AW) - 1 - r, 1'b1, 1'b1, 0, 8'h3C ^ r, 8'h3C ^ r);
    // Neighbouring word left intact by the dual writes
    access(0, 0, 1'b1, 1'b1, 0, v0(0, 0), v1(0, 0));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule